// File: doc/BRIEF.md
# Supply Reset and Low-Battery Monitor

This block sequences the digital side of power-up for a radio front end. It watches four supply and oscillator indications. The first is a power-good flag for the digital rail. The next two are comparator flags that say whether the output rail is above its upper (reset) threshold and above its lower (clock) threshold. The last is a flag that says the crystal oscillator has reached full amplitude. From these it drives four outputs:

- an active-low reset pin for the attached controller;
- a reset that forces the control registers to their defaults;
- an enable for the clock output pin;
- a sticky low-battery status bit.

The comparator and oscillator inputs arrive from analog circuits, so every flag is first passed through a synchronizer. The comparator flags are also debounced, so a short dip does not pulse the reset pin. The low-battery bit works from the synchronized but undebounced upper-threshold flag, so it records dips that the reset path ignores. It stays set until the rail is back above threshold and either software reads the status register or the reset pin is low. The clock enable is a plain level. The first clock cycle on the pin may therefore be truncated, and the block accepts this.

Top module: `supply_rst_mon`

## Requirements
- R1: `regs_default` is high while `rst` is high. It is also high on the cycle after the filtered digital power-good flag is low. Counted from a change on `dig_pgood`, it follows 4 clock edges later.
- R2: `rst_pin_n` goes high only on the edge after the filtered power-good, upper-threshold and oscillator-ready flags are all true. A rise of `rail_hi_ok` reaches `rst_pin_n` after 7 edges.
- R3: When any of those three filtered flags drops, `rst_pin_n` goes low on the next edge. Releasing it again needs all three flags once more.
- R4: `clk_out_en` is high exactly on the edge after the filtered power-good, lower-threshold and oscillator-ready flags are all true.
- R5: `low_batt` becomes 1 on the edge after the synchronized upper-threshold flag is low. This is 3 edges after `rail_hi_ok` falls.
- R6: `low_batt` clears to 0 on an edge where the synchronized upper-threshold flag is high and either `stat_rd` is high or `rst_pin_n` is low.
- R7: While the synchronized upper-threshold flag is low, a `stat_rd` pulse leaves `low_batt` at 1, including on the very cycle of the read.
- R8: A comparator flag changes its filtered value only after its synchronized value has differed from it for `CMP_STABLE` (default 4) consecutive cycles. A shorter dip on `rail_hi_ok` leaves `rst_pin_n` high.
- R9: While `rst` is high, the outputs are: `rst_pin_n`=0, `clk_out_en`=0, `regs_default`=1, `low_batt`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| dig_pgood | input | 1 | Digital rail power good (asynchronous) |
| rail_hi_ok | input | 1 | Output rail above the reset/low-battery threshold (asynchronous) |
| rail_lo_ok | input | 1 | Output rail above the clock-enable threshold (asynchronous) |
| osc_ready | input | 1 | Oscillator amplitude reached (asynchronous) |
| stat_rd | input | 1 | One-cycle strobe: status register is being read |
| rst_pin_n | output | 1 | Active-low reset pin, registered |
| regs_default | output | 1 | Forces control registers to defaults, registered |
| clk_out_en | output | 1 | Clock output pin enable, registered |
| low_batt | output | 1 | Sticky low-battery status bit, registered |

## Verification
Counted in clock edges from an input change, the outputs follow at these distances:

- `dig_pgood` and `osc_ready` reach the reset, default and clock-enable outputs after 4 edges: two synchronizer stages, one filter stage and the output register.
- A comparator change reaches those outputs after 2 + `CMP_STABLE` + 1 edges.
- A fall of `rail_hi_ok` reaches `low_batt` after 3 edges.
- A `stat_rd` strobe acts on the next edge.

A behavioural model in the bench keeps delay-line history and run-length counts, and steps through the same edges. It is compared with every output at each falling clock edge. Directed checks then sample at exactly the edges listed above, one edge before and at the due edge. This shows both that nothing moves early and that the change arrives on time.

// File: rtl/srm_pkg.sv
package srm_pkg;
  typedef struct packed {
    logic pg;
    logic hi;
    logic lo;
    logic osc;
  } flags_t;

  localparam int FLAG_PG  = 0;
  localparam int FLAG_HI  = 1;
  localparam int FLAG_LO  = 2;
  localparam int FLAG_OSC = 3;
  localparam int NFLAGS   = 4;
endpackage

// File: rtl/srm_flag_filter.sv
module srm_flag_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int STABLE_CYC  = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic sync_o,
  output logic filt_o
);
  localparam int CW = (STABLE_CYC > 1) ? $clog2(STABLE_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(STABLE_CYC - 1);

  logic [SYNC_STAGES-1:0] pipe;
  logic [CW-1:0]          run;
  logic                   filt_q;

  always_ff @(posedge clk) begin
    if (rst) pipe <= '0;
    else     pipe <= {pipe[SYNC_STAGES-2:0], async_in};
  end

  assign sync_o = pipe[SYNC_STAGES-1];

  // Filtered value follows only after a full run of disagreeing samples.
  always_ff @(posedge clk) begin
    if (rst) begin
      filt_q <= 1'b0;
      run    <= '0;
    end else if (sync_o == filt_q) begin
      run <= '0;
    end else if (run == LAST) begin
      filt_q <= sync_o;
      run    <= '0;
    end else begin
      run <= run + 1'b1;
    end
  end

  assign filt_o = filt_q;

  a_r8_agree_holds: assert property (@(posedge clk) disable iff (rst)
    (sync_o == filt_q) |=> $stable(filt_q));
endmodule

// File: rtl/srm_reset_seq.sv
module srm_reset_seq
  import srm_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  flags_t flt,
  output logic   rst_pin_n,
  output logic   regs_default,
  output logic   clk_out_en
);
  logic rel_ok, oe_ok;

  assign rel_ok = flt.pg & flt.hi & flt.osc;
  assign oe_ok  = flt.pg & flt.lo & flt.osc;

  always_ff @(posedge clk) begin
    if (rst) begin
      rst_pin_n    <= 1'b0;
      clk_out_en   <= 1'b0;
      regs_default <= 1'b1;
    end else begin
      rst_pin_n    <= rel_ok;
      clk_out_en   <= oe_ok;
      regs_default <= ~flt.pg;
    end
  end

  a_r2_release_needs_all: assert property (@(posedge clk) disable iff (rst)
    rst_pin_n |-> $past(flt.pg && flt.hi && flt.osc));
  a_r3_drop_reasserts: assert property (@(posedge clk) disable iff (rst)
    !(flt.pg && flt.hi && flt.osc) |=> !rst_pin_n);
  a_r4_clk_enable_cond: assert property (@(posedge clk) disable iff (rst)
    clk_out_en |-> $past(flt.pg && flt.lo && flt.osc));
  a_r1_pgood_low_defaults: assert property (@(posedge clk) disable iff (rst)
    !flt.pg |=> regs_default);
endmodule

// File: rtl/srm_lowbatt.sv
module srm_lowbatt (
  input  logic clk,
  input  logic rst,
  input  logic hi_sync,
  input  logic stat_rd,
  input  logic rst_pin_n,
  output logic low_batt
);
  always_ff @(posedge clk) begin
    if (rst)                         low_batt <= 1'b0;
    else if (!hi_sync)               low_batt <= 1'b1;
    else if (stat_rd || !rst_pin_n)  low_batt <= 1'b0;
  end

  a_r5_dip_sets: assert property (@(posedge clk) disable iff (rst)
    !hi_sync |=> low_batt);
  a_r7_read_while_low: assert property (@(posedge clk) disable iff (rst)
    (!hi_sync && stat_rd) |=> low_batt);
  a_r6_clear_cause: assert property (@(posedge clk) disable iff (rst)
    ($fell(low_batt) && !$past(rst)) |->
      ($past(hi_sync) && ($past(stat_rd) || !$past(rst_pin_n))));
endmodule

// File: rtl/supply_rst_mon.sv
module supply_rst_mon #(
  parameter int SYNC_STAGES = 2,
  parameter int CMP_STABLE  = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic dig_pgood,
  input  logic rail_hi_ok,
  input  logic rail_lo_ok,
  input  logic osc_ready,
  input  logic stat_rd,
  output logic rst_pin_n,
  output logic regs_default,
  output logic clk_out_en,
  output logic low_batt
);
  import srm_pkg::*;

  logic [NFLAGS-1:0] raw, synced, filtered;
  flags_t            flt;

  assign raw[FLAG_PG]  = dig_pgood;
  assign raw[FLAG_HI]  = rail_hi_ok;
  assign raw[FLAG_LO]  = rail_lo_ok;
  assign raw[FLAG_OSC] = osc_ready;

  for (genvar g = 0; g < NFLAGS; g++) begin : g_flag
    localparam int STB = (g == FLAG_HI || g == FLAG_LO) ? CMP_STABLE : 1;
    srm_flag_filter #(.SYNC_STAGES(SYNC_STAGES), .STABLE_CYC(STB)) u_filt (
      .clk(clk), .rst(rst), .async_in(raw[g]),
      .sync_o(synced[g]), .filt_o(filtered[g])
    );
  end

  assign flt.pg  = filtered[FLAG_PG];
  assign flt.hi  = filtered[FLAG_HI];
  assign flt.lo  = filtered[FLAG_LO];
  assign flt.osc = filtered[FLAG_OSC];

  srm_reset_seq u_seq (
    .clk(clk), .rst(rst), .flt(flt),
    .rst_pin_n(rst_pin_n), .regs_default(regs_default), .clk_out_en(clk_out_en)
  );

  srm_lowbatt u_lb (
    .clk(clk), .rst(rst), .hi_sync(synced[FLAG_HI]), .stat_rd(stat_rd),
    .rst_pin_n(rst_pin_n), .low_batt(low_batt)
  );

  a_r9_reset_state: assert property (@(posedge clk)
    $past(rst) |-> (!rst_pin_n && !clk_out_en && regs_default && !low_batt));
endmodule

// File: tb/supply_rst_mon_test.sv
module supply_rst_mon_test;
  localparam int SYNC = 2;
  localparam int CMP  = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pg = 1'b0, hi = 1'b0, lo = 1'b0, osc = 1'b0, rd = 1'b0;
  logic rst_pin_n, regs_default, clk_out_en, low_batt;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  supply_rst_mon #(.SYNC_STAGES(SYNC), .CMP_STABLE(CMP)) uut (
    .clk(clk), .rst(rst), .dig_pgood(pg), .rail_hi_ok(hi), .rail_lo_ok(lo),
    .osc_ready(osc), .stat_rd(rd), .rst_pin_n(rst_pin_n),
    .regs_default(regs_default), .clk_out_en(clk_out_en), .low_batt(low_batt)
  );

  // Reference model: delay-line history per flag and a run-length count of
  // samples that disagree with the accepted value.
  bit [7:0] hist [4];
  bit       acc  [4];
  int       runl [4];
  int       need [4] = '{1, CMP, CMP, 1};
  bit m_rstn = 0, m_oe = 0, m_dflt = 1, m_lb = 0;
  bit cur [4];
  bit sy  [4];
  bit ac  [4];

  always @(posedge clk) begin
    cur = '{pg, hi, lo, osc};
    if (rst) begin
      for (int f = 0; f < 4; f++) begin hist[f] = '0; acc[f] = 0; runl[f] = 0; end
      m_rstn = 0; m_oe = 0; m_dflt = 1; m_lb = 0;
    end else begin
      for (int f = 0; f < 4; f++) begin sy[f] = hist[f][SYNC-1]; ac[f] = acc[f]; end
      if (!sy[1]) m_lb = 1;
      else if (rd || !m_rstn) m_lb = 0;
      m_rstn = ac[0] && ac[1] && ac[3];
      m_oe   = ac[0] && ac[2] && ac[3];
      m_dflt = !ac[0];
      for (int f = 0; f < 4; f++) begin
        if (sy[f] == acc[f]) runl[f] = 0;
        else begin
          runl[f]++;
          if (runl[f] >= need[f]) begin acc[f] = sy[f]; runl[f] = 0; end
        end
        hist[f] = {hist[f][6:0], cur[f]};
      end
    end
  end

  task automatic chk(input string req, input string nm, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%b expected=%b t=%0t", req, nm, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R2/R3", "rst_pin_n", rst_pin_n, m_rstn);
      chk("R4", "clk_out_en", clk_out_en, m_oe);
      chk("R1", "regs_default", regs_default, m_dflt);
      chk("R5/R6", "low_batt", low_batt, m_lb);
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    step(3);
    chk("R9", "rst_pin_n", rst_pin_n, 1'b0);
    chk("R9", "clk_out_en", clk_out_en, 1'b0);
    chk("R9", "regs_default", regs_default, 1'b1);
    chk("R9", "low_batt", low_batt, 1'b0);
    rst = 1'b0;
    step(4);
    chk("R5", "low_batt after start", low_batt, 1'b1);
    pg = 1'b1;
    step(3);
    chk("R1", "defaults held one edge early", regs_default, 1'b1);
    step(1);
    chk("R1", "defaults released", regs_default, 1'b0);
    lo = 1'b1; osc = 1'b1;
    step(10);
    chk("R4", "clock enabled", clk_out_en, 1'b1);
    chk("R2", "reset held without upper flag", rst_pin_n, 1'b0);
    rd = 1'b1; step(1); rd = 1'b0;
    chk("R7", "read while low", low_batt, 1'b1);
    hi = 1'b1;
    step(6);
    chk("R2", "release one edge early", rst_pin_n, 1'b0);
    step(1);
    chk("R2", "release due", rst_pin_n, 1'b1);
    chk("R6", "cleared during reset", low_batt, 1'b0);
    hi = 1'b0; step(3); hi = 1'b1;
    step(8);
    chk("R8", "short dip ignored", rst_pin_n, 1'b1);
    chk("R5", "short dip recorded", low_batt, 1'b1);
    rd = 1'b1; step(1); rd = 1'b0;
    chk("R6", "read clears", low_batt, 1'b0);
    osc = 1'b0;
    step(3);
    chk("R3", "osc drop one edge early", rst_pin_n, 1'b1);
    step(1);
    chk("R3", "osc drop reasserts", rst_pin_n, 1'b0);
    chk("R4", "osc drop gates clock", clk_out_en, 1'b0);
    osc = 1'b1;
    step(10);
    hi = 1'b0;
    step(2);
    chk("R5", "one edge early", low_batt, 1'b0);
    step(1);
    chk("R5", "dip due", low_batt, 1'b1);
    step(10);
    chk("R3", "long dip reasserts", rst_pin_n, 1'b0);
    chk("R4", "lower flag still good", clk_out_en, 1'b1);
    pg = 1'b0;
    step(4);
    chk("R1", "power-good loss defaults", regs_default, 1'b1);
    chk("R4", "power-good loss gates clock", clk_out_en, 1'b0);
    pg = 1'b1; hi = 1'b1;
    step(12);
    chk("R2", "recovered", rst_pin_n, 1'b1);
    chk("R6", "recovered clears", low_batt, 1'b0);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule